// File: doc/BRIEF.md
# Serial ADC Frame Sampler

The block pulls conversion results from a three-wire serial analog-to-digital converter that has nothing to configure. The converter is never written to: the block only drives an active-low chip select and a serial clock, and it listens on one data line. A frame opens with two clock cycles that carry nothing useful. Then 10 or 12 data bits follow, most significant first. The width is chosen by one select input, and the port list stays the same for both widths.

A frame is started in one of two ways: by a one-cycle start request, or by a free-running rate timer while continuous mode is enabled. The serial clock is divided down from the system clock. The division ratio is raised automatically whenever the requested ratio would push the serial clock above 14 MHz. Each finished frame leaves a right-aligned sample word and a one-cycle valid strobe. A sample memory downstream can take the word directly.

Top module: `adc_sampler`

## Requirements
- R1: While reset is asserted and after it is released, with no frame started, cs_no is 1, sclk_o is 0, valid_o is 0 and data_o is 0.
- R2: A frame opens when cs_no goes low while sclk_o is low. sclk_o then stays low for one full half-period before its first rising edge. sclk_o is never high while cs_no is high.
- R3: A frame has 2 + W rising edges on sclk_o. W is 10 when res_i is 0 and 12 when res_i is 1, and res_i is sampled at frame start. The two bits taken on the first two rising edges are dropped. In 10-bit mode, data_o[11:10] are 0.
- R4: miso_i is sampled on each rising edge of sclk_o. The first data bit becomes the most significant bit of the result.
- R5: Each half-period of sclk_o lasts H system clocks. H = max(HALF_DIV, ceil(SYS_CLK_HZ / (2 * SCLK_MAX_HZ))). With a 250 MHz system clock this gives H = 9 for any HALF_DIV up to 9.
- R6: valid_o goes high for exactly one cycle, in the cycle in which cs_no rises at the end of the last clock phase. data_o changes only in that cycle and holds its value until the next one.
- R7: After the last falling edge, cs_no stays high for at least one half-period before the next frame can start. A start_i pulse during a frame is ignored.
- R8: While cont_i is 1, frames start every P system clocks, where P = max(PERIOD, (2 * (2 + 12) + 2) * H + 1). With the defaults, P is 271. A frame starts at once if P or more clocks have passed since the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request for a single frame |
| cont_i | input | 1 | Continuous sampling enable |
| res_i | input | 1 | Resolution select: 0 = 10 bits, 1 = 12 bits |
| miso_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| data_o | output | 12 | Last sample, right aligned |
| valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The converter model drives ones on both lead bits. A design that kept a lead bit would therefore show it in the top bits of the result. The sample values are chosen so that a reversed bit order or a one-bit shift is visible: asymmetric patterns, all zeros, all ones and a lone MSB. They alternate between the two resolutions, and res_i is flipped in the middle of frames to show that the width is fixed at frame start. Start pulses inside a frame and a run of continuous frames check the launch timing, and a second instance with a far too small divider and period must match the first one cycle for cycle, which shows that both limits are enforced.

// File: rtl/adc_sampler_pkg.sv
package adc_sampler_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_st_e;

  function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
  parameter int unsigned PER = 271
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  output logic due_o
);

  localparam int unsigned PC_W = $clog2(PER);
  localparam logic [PC_W-1:0] LAST = PC_W'(PER - 1);

  logic [PC_W-1:0] cnt_q;

  // saturates at LAST so a long idle gap makes the next frame due at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LAST;
    end else if (launch_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign due_o = (cnt_q == LAST);

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_sampler_pkg::*;
#(
  parameter int unsigned HALF  = 9,
  parameter int unsigned NB_LO = 12,
  parameter int unsigned NB_HI = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic res_i,
  output logic busy_o,
  output logic res_o,
  output logic cs_no,
  output logic sclk_o,
  output logic cap_o,
  output logic done_o
);

  localparam int unsigned PH_W = $clog2(2 * NB_HI + 2);
  localparam int unsigned HC_W = $clog2(HALF + 1);
  localparam logic [PH_W-1:0] END_LO = PH_W'(2 * NB_LO);
  localparam logic [PH_W-1:0] END_HI = PH_W'(2 * NB_HI);

  seq_st_e         st_q;
  logic [HC_W-1:0] hcnt_q;
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] end_ph;
  logic            res_q;
  logic            run;
  logic            hend;
  logic            fin;

  assign run    = (st_q == ST_RUN);
  assign hend   = (hcnt_q == HC_W'(HALF - 1));
  assign end_ph = res_q ? END_HI : END_LO;

  // phase 0: setup, odd phases: sclk high, even phases: low, end_ph+1: cs gap
  assign cap_o  = run && hend && !ph_q[0] && (ph_q < end_ph);
  assign done_o = run && hend && (ph_q == end_ph);
  assign fin    = run && hend && (ph_q == end_ph + PH_W'(1));
  assign busy_o = run;
  assign res_o  = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      hcnt_q <= '0;
      ph_q   <= '0;
      res_q  <= 1'b0;
      cs_no  <= 1'b1;
      sclk_o <= 1'b0;
    end else if (launch_i) begin
      st_q   <= ST_RUN;
      hcnt_q <= '0;
      ph_q   <= '0;
      res_q  <= res_i;
      cs_no  <= 1'b0;
      sclk_o <= 1'b0;
    end else if (run) begin
      if (hend) begin
        hcnt_q <= '0;
        ph_q   <= ph_q + 1'b1;
        sclk_o <= cap_o;
        if (done_o) cs_no <= 1'b1;
        if (fin) st_q <= ST_IDLE;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_shift_in.sv
module adc_shift_in #(
  parameter int unsigned RES_LO = 10,
  parameter int unsigned RES_HI = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              done_i,
  input  logic              res_i,
  input  logic              miso_i,
  output logic [RES_HI-1:0] data_o,
  output logic              valid_o
);

  logic [RES_HI-1:0] sh_q;
  logic [RES_HI-1:0] word;

  // lead bits fall off the top of the register; only the data bits remain
  generate
    if (RES_HI > RES_LO) begin : g_pad
      assign word = res_i ? sh_q : {{(RES_HI - RES_LO){1'b0}}, sh_q[RES_LO-1:0]};
    end else begin : g_flat
      assign word = sh_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      if (cap_i) sh_q <= {sh_q[RES_HI-2:0], miso_i};
      valid_o <= done_i;
      if (done_i) data_o <= word;
    end
  end

endmodule

// File: rtl/adc_sampler.sv
module adc_sampler
  import adc_sampler_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ  = 250_000_000,
  parameter int unsigned SCLK_MAX_HZ = 14_000_000,
  parameter int unsigned HALF_DIV    = 9,
  parameter int unsigned PERIOD      = 250,
  parameter int unsigned LEAD        = 2,
  parameter int unsigned RES_LO      = 10,
  parameter int unsigned RES_HI      = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic              res_i,
  input  logic              miso_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic [RES_HI-1:0] data_o,
  output logic              valid_o
);

  // divider and period are clamped so sclk and the frame rate stay legal
  localparam int unsigned MIN_HALF  = ceil_div(SYS_CLK_HZ, 2 * SCLK_MAX_HZ);
  localparam int unsigned HALF_EFF  = max_u(HALF_DIV, MIN_HALF);
  localparam int unsigned NB_LO     = LEAD + RES_LO;
  localparam int unsigned NB_HI     = LEAD + RES_HI;
  localparam int unsigned FRAME_MAX = (2 * NB_HI + 2) * HALF_EFF;
  localparam int unsigned PER_EFF   = max_u(PERIOD, FRAME_MAX + 1);

  logic busy;
  logic due;
  logic launch;
  logic cap;
  logic done;
  logic res_q;

  assign launch = !busy && (start_i || (cont_i && due));

  adc_rate_timer #(
    .PER(PER_EFF)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .due_o   (due)
  );

  adc_frame_seq #(
    .HALF (HALF_EFF),
    .NB_LO(NB_LO),
    .NB_HI(NB_HI)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .res_i   (res_i),
    .busy_o  (busy),
    .res_o   (res_q),
    .cs_no   (cs_no),
    .sclk_o  (sclk_o),
    .cap_o   (cap),
    .done_o  (done)
  );

  adc_shift_in #(
    .RES_LO(RES_LO),
    .RES_HI(RES_HI)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .done_i (done),
    .res_i  (res_q),
    .miso_i (miso_i),
    .data_o (data_o),
    .valid_o(valid_o)
  );

endmodule

// File: rtl/adc_sampler_chk.sv
module adc_sampler_chk #(
  parameter int unsigned HALF  = 9,
  parameter int unsigned NB_LO = 12,
  parameter int unsigned NB_HI = 14,
  parameter int unsigned DW    = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_no,
  input logic          sclk_o,
  input logic          valid_o,
  input logic [DW-1:0] data_o
);

  logic        sclk_d;
  logic [15:0] run_q;
  logic [15:0] gap_q;
  logic [7:0]  rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      run_q  <= '0;
      gap_q  <= '1;
      rise_q <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (sclk_o != sclk_d) run_q <= 16'd1;
      else if (run_q != '1) run_q <= run_q + 1'b1;
      if (!cs_no) gap_q <= '0;
      else if (gap_q != '1) gap_q <= gap_q + 1'b1;
      if (!cs_no && sclk_o && !sclk_d) rise_q <= rise_q + 1'b1;
      else if (cs_no && !valid_o) rise_q <= '0;
    end
  end

  AST_SCLK_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no); // R2
  AST_CS_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |=> !sclk_o); // R2
  AST_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_d && !sclk_o) |-> (run_q == 16'(HALF))); // R5
  AST_BIT_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (rise_q == 8'(NB_LO) || rise_q == 8'(NB_HI))); // R3
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R6
  AST_VALID_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cs_no && !sclk_o)); // R6
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o)); // R6
  AST_CS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (gap_q >= 16'(HALF))); // R7

endmodule

bind adc_sampler adc_sampler_chk #(
  .HALF (HALF_EFF),
  .NB_LO(NB_LO),
  .NB_HI(NB_HI),
  .DW   (RES_HI)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_no  (cs_no),
  .sclk_o (sclk_o),
  .valid_o(valid_o),
  .data_o (data_o)
);

// File: tb/sim_adc_sampler.sv
`timescale 1ns/1ps
module sim_adc_sampler;

  // expected timing derived from the requirements (R5, R8)
  localparam int MIN_H = (250_000_000 + 28_000_000 - 1) / 28_000_000;
  localparam int H     = (9 > MIN_H) ? 9 : MIN_H;
  localparam int L_HI  = (2 * 14 + 2) * H;
  localparam int P     = (250 > L_HI) ? 250 : L_HI + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cont = 1'b0;
  logic res = 1'b0;
  logic miso = 1'b0;

  logic        cs0, sclk0, valid0;
  logic [11:0] data0;
  logic        cs1, sclk1, valid1;
  logic [11:0] data1;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  adc_sampler u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cont_i(cont), .res_i(res),
    .miso_i(miso), .cs_no(cs0), .sclk_o(sclk0), .data_o(data0), .valid_o(valid0)
  );

  // divider and period requested far too small: must clamp to the same timing
  adc_sampler #(.HALF_DIV(2), .PERIOD(5)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cont_i(cont), .res_i(res),
    .miso_i(miso), .cs_no(cs1), .sclk_o(sclk1), .data_o(data1), .valid_o(valid1)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // converter model: two lead bits of 1, then data MSB first, shifted on sclk fall
  int dev_q[$];
  int exp_q[$];
  int dev_w, dev_nb, dev_idx;
  logic cs_seen = 1'b1, sclk_seen = 1'b0;

  always @(negedge clk) begin
    if (cs_seen && !cs0) begin
      int v;
      v = (dev_q.size() > 0) ? dev_q.pop_front() : 0;
      dev_nb = res ? 14 : 12;
      dev_w = (3 << (dev_nb - 2)) | (v & ((1 << (dev_nb - 2)) - 1));
      dev_idx = 0;
      miso = dev_w[dev_nb - 1];
    end else if (!cs0 && sclk_seen && !sclk0) begin
      dev_idx++;
      miso = (dev_idx < dev_nb) ? dev_w[dev_nb - 1 - dev_idx] : 1'b0;
    end
    cs_seen = cs0;
    sclk_seen = sclk0;
  end

  // behavioural reference: cycles since launch
  bit m_busy = 0;
  int m_k = 0;
  int m_since = P - 1;
  int m_nb = 12;
  int m_exp = 0;
  int m_last = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_k = 0; m_since = P - 1; m_nb = 12; m_last = 0;
    end else begin
      if (!m_busy && (start || (cont && m_since >= P - 1))) begin
        m_busy = 1; m_k = 0; m_since = 0;
        m_nb = res ? 14 : 12;
        m_exp = (exp_q.size() > 0) ? exp_q.pop_front() : 0;
        m_exp = m_exp & (res ? 12'hFFF : 12'h3FF);
      end else begin
        if (m_since < P - 1) m_since++;
        if (m_busy) begin
          m_k++;
          if (m_k == (2 * m_nb + 2) * H) m_busy = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int ph;
      bit e_cs, e_sclk, e_valid;
      ph = m_k / H;
      e_cs = m_busy ? (ph > 2 * m_nb) : 1'b1;
      e_sclk = m_busy && (ph % 2 == 1) && (ph <= 2 * m_nb);
      e_valid = m_busy && (m_k == (2 * m_nb + 1) * H);
      if (e_valid) m_last = m_exp;
      check(cs0 == e_cs, "R2 R7 R8 cs_no", cs0, e_cs);
      check(sclk0 == e_sclk, "R5 sclk_o", sclk0, e_sclk);
      check(valid0 == e_valid, "R6 valid_o", valid0, e_valid);
      check(data0 == m_last[11:0], "R3 R4 data_o", data0, m_last);
      check({cs1, sclk1, valid1, data1} == {cs0, sclk0, valid0, data0},
            "R5 clamped instance", {cs1, sclk1, valid1, data1}, {cs0, sclk0, valid0, data0});
    end
  end

  task automatic one_frame(input bit r, input int v);
    dev_q.push_back(v);
    exp_q.push_back(v);
    @(negedge clk); res = r; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (60) @(negedge clk);
    start = 1'b1;                 // R7: ignored mid-frame
    res = ~r;                     // R3: width fixed at frame start
    @(negedge clk); start = 1'b0;
    repeat (260) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(cs0 == 1'b1 && sclk0 == 1'b0 && valid0 == 1'b0 && data0 == 12'h0,
          "R1 in reset", {cs0, sclk0, valid0, data0}, 15'h4000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cs0 == 1'b1 && sclk0 == 1'b0 && valid0 == 1'b0 && data0 == 12'h0,
          "R1 after reset", {cs0, sclk0, valid0, data0}, 15'h4000);
    one_frame(1'b0, 12'h2A5);
    one_frame(1'b1, 12'hABC);
    one_frame(1'b1, 12'h800);
    one_frame(1'b0, 12'h001);
    one_frame(1'b1, 12'hFFF);
    one_frame(1'b0, 12'hC35);
    one_frame(1'b1, 12'h000);
    // R8: continuous run with both resolutions
    for (int i = 0; i < 10; i++) begin
      dev_q.push_back(12'h5A3 ^ (i * 12'h111));
      exp_q.push_back(12'h5A3 ^ (i * 12'h111));
    end
    @(negedge clk); res = 1'b1; cont = 1'b1;
    repeat (3 * P) @(negedge clk);
    res = 1'b0;
    repeat (3 * P) @(negedge clk);
    cont = 1'b0;
    repeat (400) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R8 actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule